// File: doc/BRIEF.md
# Dual Serial-Memory Port Multiplexer

This block sits between two octal serial-memory controllers and two external pin ports. Each controller bus has a serial clock, an active-low select, eight data outputs with per-bit output enables, and eight data inputs. A two-bit mode field sets the routing. In the straight and crossed modes each controller owns one port. In the two shared modes both controllers take turns on a single port, and the other port is parked.

In a shared mode a controller raises a request and waits for its grant. The grant covers one transaction. A transaction starts when that controller pulls its select low and ends when the select returns high. When both controllers are waiting, the grants alternate. After each transaction an idle gap, set in system clock cycles, must pass before the next grant. Every port has two select lines. A two-bit steering field picks, for each controller, the line on which its select appears.

There is no streaming data path here. Every pin is a plain level signal, so no valid/ready handshake applies. Every output and every returned data word goes through exactly one register stage, whatever the mode.

Top module: `serial_port_mux`

## Requirements
- R1: Reset leaves mode 0 and steering 0 in effect. After reset every port select line is high, every port output enable is 0, every port serial clock is 0, both returned data words are 0, and `c_gnt` is 2'b11.
- R2: Mode 0 (straight). Controller 0 appears on port 0 and controller 1 appears on port 1, one cycle after the inputs. Clock, select, data and output enables all follow this routing.
- R3: Mode 2 (crossed). Controller 0 appears on port 1 and controller 1 appears on port 0, one cycle later. Each controller receives the input data of the port it drives.
- R4: Mode 1 (shared on port 0). Only the granted controller drives port 0. Port 1 holds both select lines high and its output enables at 0.
- R5: Mode 3 (shared on port 1). Only the granted controller drives port 1. Port 0 is parked in the same way as the unused port in R4.
- R6: Steering bit 0 routes controller 0's select and steering bit 1 routes controller 1's select. A bit value of 0 places the select on line 0 of the port (`p_ncs[2p]`), and 1 places it on line 1 (`p_ncs[2p+1]`). The line not chosen stays high.
- R7: In a shared mode at most one grant bit is high. When both controllers request, the grant alternates between them. The first tie after reset goes to controller 0.
- R8: In a shared mode, after the granted select goes high, both grants stay low for exactly gap+1 cycles before the next grant.
- R9: A grant holds once the owner's select has gone low, even if the owner drops its request. The grant ends when the select returns high. A grant whose owner drops its request before pulling its select low is withdrawn on the next cycle.
- R10: In a shared mode a controller without a grant receives data 0. Its clock, select and data reach no port.
- R11: A new mode or steering value takes effect only when both controller selects are high, no grant is held and no gap is running.
- R12: Each controller receives the input data of the port it drives, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Routing mode: 0 straight, 1 shared on port 0, 2 crossed, 3 shared on port 1 |
| cfg_steer | input | 2 | Per-controller select line choice; bit c is for controller c |
| cfg_gap | input | GAP_W | Idle cycles between shared transactions |
| c_req | input | 2 | Per-controller request for a shared port |
| c_gnt | output | 2 | Per-controller grant; 2'b11 in the non-shared modes |
| c_sck | input | 2 | Controller serial clocks |
| c_ncs | input | 2 | Controller selects, active low |
| c_dq_o | input | 2*DQ_W | Controller output data, controller c in slice c |
| c_dq_oe | input | 2*DQ_W | Controller per-bit output enables |
| c_dq_i | output | 2*DQ_W | Data returned to each controller |
| p_sck | output | 2 | Port serial clocks |
| p_ncs | output | 4 | Port select lines, port p line l at bit 2p+l, active low |
| p_dq_o | output | 2*DQ_W | Port output data, port p in slice p |
| p_dq_oe | output | 2*DQ_W | Port per-bit output enables |
| p_dq_i | input | 2*DQ_W | Data read from each port |

## Verification
The cases of interest are those where a configuration change collides with live traffic. In one case a new mode is presented while a select is still low. The bench checks that the port routing stays unchanged for several cycles. After the selects go high, the new routing must show on the ports within two cycles. In the other case, an ungranted controller drives its select and data in the same cycles that the granted controller drives its own. The parked port must stay quiet, the shared port must carry only the owner's values, and the ungranted controller must read zeros. The gap is measured at `c_grant` both with a nonzero setting and with zero.

// File: rtl/smux_pkg.sv
package smux_pkg;

  localparam int NCTRL = 2;
  localparam int NLINE = 2;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_SHARE_P0 = 2'd1,
    MODE_SWAP     = 2'd2,
    MODE_SHARE_P1 = 2'd3
  } mux_mode_e;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_OWN  = 2'd1,
    ARB_GAP  = 2'd2
  } arb_st_e;

  function automatic logic mode_shared(mux_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/smux_cfg_hold.sv
module smux_cfg_hold
  import smux_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mux_mode_e       mode_in,
  input  logic [SW-1:0]   steer_in,
  input  logic            quiet,
  output mux_mode_e       mode_q,
  output logic [SW-1:0]   steer_q
);

  // new settings are adopted only while nothing is in flight
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_DIRECT;
      steer_q <= '0;
    end else if (quiet) begin
      mode_q  <= mode_in;
      steer_q <= steer_in;
    end
  end

endmodule

// File: rtl/smux_arbiter.sv
module smux_arbiter
  import smux_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shared,
  input  logic [NCTRL-1:0] req,
  input  logic [NCTRL-1:0] ncs,
  input  logic [GAP_W-1:0] gap,
  output logic [NCTRL-1:0] gnt,
  output logic             quiet
);

  arb_st_e          st;
  logic             owner;
  logic             last;
  logic             started;
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ARB_IDLE;
      owner   <= 1'b0;
      last    <= 1'b1;
      started <= 1'b0;
      cnt     <= '0;
    end else if (!shared) begin
      st      <= ARB_IDLE;
      started <= 1'b0;
      cnt     <= '0;
    end else begin
      unique case (st)
        ARB_IDLE: begin
          if (|req) begin
            st      <= ARB_OWN;
            owner   <= (&req) ? ~last : req[1];
            started <= 1'b0;
          end
        end
        ARB_OWN: begin
          if (!started) begin
            if (!ncs[owner]) begin
              started <= 1'b1;
            end else if (!req[owner]) begin
              st   <= ARB_IDLE;
              last <= owner;
            end
          end else if (ncs[owner]) begin
            started <= 1'b0;
            last    <= owner;
            if (gap == '0) begin
              st <= ARB_IDLE;
            end else begin
              st  <= ARB_GAP;
              cnt <= gap;
            end
          end
        end
        ARB_GAP: begin
          if (cnt <= GAP_W'(1)) st <= ARB_IDLE;
          else                  cnt <= cnt - 1'b1;
        end
        default: st <= ARB_IDLE;
      endcase
    end
  end

  always_comb begin
    gnt = '0;
    if (st == ARB_OWN) gnt[owner] = 1'b1;
  end

  assign quiet = (st == ARB_IDLE);

endmodule

// File: rtl/smux_port_drv.sv
module smux_port_drv
  import smux_pkg::*;
#(
  parameter int DQ_W = 8,
  parameter bit PORT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mux_mode_e             mode,
  input  logic [NCTRL-1:0]      steer,
  input  logic [NCTRL-1:0]      gnt,
  input  logic [NCTRL-1:0]      c_sck,
  input  logic [NCTRL-1:0]      c_ncs,
  input  logic [NCTRL*DQ_W-1:0] c_dq_o,
  input  logic [NCTRL*DQ_W-1:0] c_dq_oe,
  output logic                  p_sck,
  output logic [NLINE-1:0]      p_ncs,
  output logic [DQ_W-1:0]       p_dq_o,
  output logic [DQ_W-1:0]       p_dq_oe
);

  logic            has;
  logic            src;
  logic [DQ_W-1:0] sel_dq;
  logic [DQ_W-1:0] sel_oe;

  always_comb begin
    has = 1'b0;
    src = 1'b0;
    unique case (mode)
      MODE_DIRECT:   begin has = 1'b1; src = PORT; end
      MODE_SWAP:     begin has = 1'b1; src = ~PORT; end
      MODE_SHARE_P0: begin has = (PORT == 1'b0) && (|gnt); src = gnt[1]; end
      MODE_SHARE_P1: begin has = (PORT == 1'b1) && (|gnt); src = gnt[1]; end
      default:       begin has = 1'b0; src = 1'b0; end
    endcase
  end

  assign sel_dq = src ? c_dq_o[2*DQ_W-1:DQ_W]  : c_dq_o[DQ_W-1:0];
  assign sel_oe = src ? c_dq_oe[2*DQ_W-1:DQ_W] : c_dq_oe[DQ_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_sck   <= 1'b0;
      p_ncs   <= '1;
      p_dq_o  <= '0;
      p_dq_oe <= '0;
    end else begin
      p_sck   <= has & c_sck[src];
      for (int l = 0; l < NLINE; l++) begin
        p_ncs[l] <= (has && (steer[src] == 1'(l))) ? c_ncs[src] : 1'b1;
      end
      p_dq_o  <= has ? sel_dq : '0;
      p_dq_oe <= has ? sel_oe : '0;
    end
  end

endmodule

// File: rtl/smux_rx_sel.sv
module smux_rx_sel
  import smux_pkg::*;
#(
  parameter int DQ_W = 8,
  parameter bit CTRL = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mux_mode_e             mode,
  input  logic                  gnt,
  input  logic [NCTRL*DQ_W-1:0] p_dq_i,
  output logic [DQ_W-1:0]       c_dq_i
);

  logic has;
  logic port;

  always_comb begin
    unique case (mode)
      MODE_DIRECT:   begin has = 1'b1; port = CTRL;  end
      MODE_SWAP:     begin has = 1'b1; port = ~CTRL; end
      MODE_SHARE_P0: begin has = gnt;  port = 1'b0;  end
      MODE_SHARE_P1: begin has = gnt;  port = 1'b1;  end
      default:       begin has = 1'b0; port = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   c_dq_i <= '0;
    else if (has) c_dq_i <= port ? p_dq_i[2*DQ_W-1:DQ_W] : p_dq_i[DQ_W-1:0];
    else          c_dq_i <= '0;
  end

endmodule

// File: rtl/serial_port_mux.sv
module serial_port_mux
  import smux_pkg::*;
#(
  parameter int DQ_W  = 8,
  parameter int GAP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic [1:0]            cfg_steer,
  input  logic [GAP_W-1:0]      cfg_gap,
  input  logic [1:0]            c_req,
  output logic [1:0]            c_gnt,
  input  logic [1:0]            c_sck,
  input  logic [1:0]            c_ncs,
  input  logic [2*DQ_W-1:0]     c_dq_o,
  input  logic [2*DQ_W-1:0]     c_dq_oe,
  output logic [2*DQ_W-1:0]     c_dq_i,
  output logic [1:0]            p_sck,
  output logic [3:0]            p_ncs,
  output logic [2*DQ_W-1:0]     p_dq_o,
  output logic [2*DQ_W-1:0]     p_dq_oe,
  input  logic [2*DQ_W-1:0]     p_dq_i
);

  mux_mode_e        mode_q;
  logic [NCTRL-1:0] steer_q;
  logic [NCTRL-1:0] arb_gnt;
  logic             arb_quiet;
  logic             cfg_quiet;
  logic             shared;

  assign shared    = mode_shared(mode_q);
  assign cfg_quiet = (&c_ncs) && arb_quiet;
  assign c_gnt     = shared ? arb_gnt : '1;

  smux_cfg_hold #(.SW(NCTRL)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_in  (mux_mode_e'(cfg_mode)),
    .steer_in (cfg_steer),
    .quiet    (cfg_quiet),
    .mode_q   (mode_q),
    .steer_q  (steer_q)
  );

  smux_arbiter #(.GAP_W(GAP_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .shared (shared),
    .req    (c_req),
    .ncs    (c_ncs),
    .gap    (cfg_gap),
    .gnt    (arb_gnt),
    .quiet  (arb_quiet)
  );

  for (genvar p = 0; p < NCTRL; p++) begin : g_port
    smux_port_drv #(.DQ_W(DQ_W), .PORT(1'(p))) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .steer   (steer_q),
      .gnt     (arb_gnt),
      .c_sck   (c_sck),
      .c_ncs   (c_ncs),
      .c_dq_o  (c_dq_o),
      .c_dq_oe (c_dq_oe),
      .p_sck   (p_sck[p]),
      .p_ncs   (p_ncs[NLINE*p +: NLINE]),
      .p_dq_o  (p_dq_o[DQ_W*p +: DQ_W]),
      .p_dq_oe (p_dq_oe[DQ_W*p +: DQ_W])
    );
  end

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    smux_rx_sel #(.DQ_W(DQ_W), .CTRL(1'(c))) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode_q),
      .gnt    (arb_gnt[c]),
      .p_dq_i (p_dq_i),
      .c_dq_i (c_dq_i[DQ_W*c +: DQ_W])
    );
  end

endmodule

// File: rtl/smux_checker.sv
module smux_checker #(
  parameter int DQ_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_q,
  input logic [1:0]        c_gnt,
  input logic [1:0]        c_ncs,
  input logic [3:0]        p_ncs,
  input logic [2*DQ_W-1:0] p_dq_oe,
  input logic [2*DQ_W-1:0] c_dq_i
);

  // R7: never two grants in a shared mode
  p_onehot_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |-> $onehot0(c_gnt));

  // R8: a new grant in a steady shared mode follows a cycle without grants
  p_gap_before_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && $past(mode_q[0]) && c_gnt != 2'b00 && c_gnt != $past(c_gnt))
      |-> $past(c_gnt) == 2'b00);

  // R4: port 1 parked while port 0 is shared
  p_park_port1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |=> (p_ncs[3:2] == 2'b11 && p_dq_oe[2*DQ_W-1:DQ_W] == '0));

  // R5: port 0 parked while port 1 is shared
  p_park_port0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |=> (p_ncs[1:0] == 2'b11 && p_dq_oe[DQ_W-1:0] == '0));

  // R6: at most one select line low per port
  p_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~p_ncs[1:0]) <= 1) && ($countones(~p_ncs[3:2]) <= 1));

  // R11: settings only change after both selects were high
  p_cfg_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(&c_ncs));

  // R10: controller 0 reads zero without a grant
  p_rx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && !c_gnt[0]) |=> (c_dq_i[DQ_W-1:0] == '0));

  // R9: a started transaction keeps its grant
  p_grant_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && c_gnt[1] && !c_ncs[1]) |=> c_gnt[1]);

endmodule

bind serial_port_mux smux_checker #(.DQ_W(DQ_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_q  (mode_q),
  .c_gnt   (c_gnt),
  .c_ncs   (c_ncs),
  .p_ncs   (p_ncs),
  .p_dq_oe (p_dq_oe),
  .c_dq_i  (c_dq_i)
);

// File: tb/serial_port_mux_test.sv
module serial_port_mux_test;

  localparam int CLK_P = 10;
  localparam int DQ_W  = 8;
  localparam int GAP_W = 8;
  localparam int WDOG  = 5000;

  localparam int K_SCK = 0, K_NCS = 1, K_DQ = 2, K_OE = 3, K_DIN = 4, K_GNT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_steer = '0;
  logic [GAP_W-1:0] cfg_gap = '0;
  logic [1:0] c_req = '0, c_gnt, c_sck = '0, c_ncs = '1;
  logic [2*DQ_W-1:0] c_dq_o = '0, c_dq_oe = '0, c_dq_i;
  logic [1:0] p_sck;
  logic [3:0] p_ncs;
  logic [2*DQ_W-1:0] p_dq_o, p_dq_oe, p_dq_i = '0;

  serial_port_mux #(.DQ_W(DQ_W), .GAP_W(GAP_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_steer(cfg_steer),
    .cfg_gap(cfg_gap), .c_req(c_req), .c_gnt(c_gnt), .c_sck(c_sck),
    .c_ncs(c_ncs), .c_dq_o(c_dq_o), .c_dq_oe(c_dq_oe), .c_dq_i(c_dq_i),
    .p_sck(p_sck), .p_ncs(p_ncs), .p_dq_o(p_dq_o), .p_dq_oe(p_dq_oe),
    .p_dq_i(p_dq_i)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int applied = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] act;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] probe(int k);
    case (k)
      K_SCK:   return 32'(p_sck);
      K_NCS:   return 32'(p_ncs);
      K_DQ:    return 32'(p_dq_o);
      K_OE:    return 32'(p_dq_oe);
      K_DIN:   return 32'(c_dq_i);
      default: return 32'(c_gnt);
    endcase
  endfunction

  // monitor: compare queued expectations as their cycle comes up
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        act = probe(sb[i].kind);
        applied++;
        if (act !== sb[i].exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h cycle=%0d",
                   sb[i].tag, sb[i].kind, act, sb[i].exp, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int off, int kind, logic [31:0] e, string tag);
    item_t it;
    it.due = cyc + off; it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #(CLK_P/4);
    end
  endtask

  task automatic set_ctrl(int c, logic sck, logic ncs, logic [7:0] dq, logic [7:0] oe);
    c_sck[c] = sck;
    c_ncs[c] = ncs;
    c_dq_o[c*DQ_W +: DQ_W] = dq;
    c_dq_oe[c*DQ_W +: DQ_W] = oe;
  endtask

  task automatic go_idle();
    set_ctrl(0, 1'b0, 1'b1, 8'h00, 8'h00);
    set_ctrl(1, 1'b0, 1'b1, 8'h00, 8'h00);
    c_req = 2'b00;
  endtask

  task automatic finish_run();
    foreach (sb[i]) begin
      fails++;
      $display("FAIL %s never sampled actual=none expected=%h", sb[i].tag, sb[i].exp);
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    go_idle();
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(1, K_NCS, 32'hF, "R1");
    expect_at(1, K_SCK, 32'h0, "R1");
    expect_at(1, K_OE,  32'h0, "R1");
    expect_at(1, K_DIN, 32'h0, "R1");
    expect_at(1, K_GNT, 32'h3, "R1");

    // R2 straight routing, R12 returned data
    tick(1);
    set_ctrl(0, 1'b1, 1'b0, 8'hA5, 8'hFF);
    set_ctrl(1, 1'b0, 1'b0, 8'h3C, 8'h0F);
    p_dq_i = 16'h6699;
    expect_at(1, K_SCK, 32'h1,    "R2");
    expect_at(1, K_NCS, 32'hA,    "R2");
    expect_at(1, K_DQ,  32'h3CA5, "R2");
    expect_at(1, K_OE,  32'h0FFF, "R2");
    expect_at(1, K_DIN, 32'h6699, "R12");

    // R11 mode presented while selects are low: no change yet
    tick(1);
    cfg_mode = 2'd2;
    expect_at(1, K_NCS, 32'hA,    "R11");
    expect_at(2, K_DQ,  32'h3CA5, "R11");
    expect_at(3, K_DIN, 32'h6699, "R11");
    tick(3);
    go_idle();
    tick(1);
    // R3 crossed routing, adopted once quiet (R11)
    set_ctrl(0, 1'b1, 1'b0, 8'h11, 8'hF0);
    set_ctrl(1, 1'b0, 1'b1, 8'h22, 8'h00);
    p_dq_i = 16'h7788;
    expect_at(1, K_SCK, 32'h2,    "R3");
    expect_at(1, K_NCS, 32'hB,    "R3");
    expect_at(1, K_DQ,  32'h1122, "R3");
    expect_at(1, K_OE,  32'hF000, "R11");
    expect_at(1, K_DIN, 32'h8877, "R3");

    // R6 steering, three settings in straight mode
    tick(1); go_idle(); cfg_mode = 2'd0; cfg_steer = 2'b01;
    tick(1); set_ctrl(0, 1'b0, 1'b0, 8'h00, 8'h00); set_ctrl(1, 1'b0, 1'b0, 8'h00, 8'h00);
    expect_at(1, K_NCS, 32'h9, "R6");
    tick(1); go_idle(); cfg_steer = 2'b10;
    tick(1); c_ncs = 2'b00;
    expect_at(1, K_NCS, 32'h6, "R6");
    tick(1); go_idle(); cfg_steer = 2'b11;
    tick(1); c_ncs = 2'b00;
    expect_at(1, K_NCS, 32'h5, "R6");

    // shared on port 0 with gap 3
    tick(1); go_idle(); cfg_steer = 2'b00; cfg_mode = 2'd1; cfg_gap = 8'd3;
    tick(1);
    c_req = 2'b11;
    expect_at(1, K_GNT, 32'h1, "R7");
    tick(1);
    // controller 1 drives without a grant: R10
    set_ctrl(0, 1'b1, 1'b0, 8'h5A, 8'hFF);
    set_ctrl(1, 1'b1, 1'b0, 8'hC3, 8'hFF);
    p_dq_i = 16'h5DE7;
    expect_at(1, K_SCK, 32'h1,    "R4");
    expect_at(1, K_NCS, 32'hE,    "R4");
    expect_at(1, K_DQ,  32'h005A, "R10");
    expect_at(1, K_OE,  32'h00FF, "R4");
    expect_at(1, K_DIN, 32'h00E7, "R10");
    tick(1);
    set_ctrl(1, 1'b0, 1'b1, 8'h00, 8'h00);
    tick(1);
    set_ctrl(0, 1'b0, 1'b1, 8'h00, 8'h00);
    // R8 gap of 3 gives 4 cycles without grant
    expect_at(1, K_GNT, 32'h0, "R8");
    expect_at(2, K_GNT, 32'h0, "R8");
    expect_at(3, K_GNT, 32'h0, "R8");
    expect_at(4, K_GNT, 32'h0, "R8");
    expect_at(5, K_GNT, 32'h2, "R7");
    tick(5);
    set_ctrl(1, 1'b1, 1'b0, 8'h96, 8'hFF);
    cfg_gap = 8'd0;
    expect_at(1, K_NCS, 32'hE,    "R4");
    expect_at(1, K_DQ,  32'h0096, "R4");
    expect_at(1, K_DIN, 32'hE700, "R10");
    tick(1);
    c_req = 2'b01;
    expect_at(1, K_GNT, 32'h2, "R9");
    tick(1);
    set_ctrl(1, 1'b0, 1'b1, 8'h00, 8'h00);
    expect_at(1, K_GNT, 32'h0, "R8");
    expect_at(2, K_GNT, 32'h1, "R8");
    tick(2);
    c_req = 2'b10;
    expect_at(1, K_GNT, 32'h0, "R9");
    expect_at(2, K_GNT, 32'h2, "R9");

    // shared on port 1, controller 1 steered to line 1
    tick(2);
    go_idle(); cfg_mode = 2'd3; cfg_steer = 2'b10;
    tick(2);
    c_req = 2'b10;
    expect_at(1, K_GNT, 32'h2, "R5");
    tick(1);
    set_ctrl(1, 1'b1, 1'b0, 8'h9C, 8'hFF);
    p_dq_i = 16'hB411;
    expect_at(1, K_SCK, 32'h2,    "R5");
    expect_at(1, K_NCS, 32'h7,    "R5");
    expect_at(1, K_DQ,  32'h9C00, "R5");
    expect_at(1, K_OE,  32'hFF00, "R5");
    expect_at(1, K_DIN, 32'hB400, "R5");

    tick(3);
    done = 1'b1;
    finish_run();
  end

endmodule